// File: doc/BRIEF.md
# Buffered-Duty PWM Output Channel

This block produces one pulse-width modulated output. An up-counting timer is paced by a fixed divide-by-four stage and then by a selectable prescaler. The timer wraps when it has just held the value of the period register. Software writes the next duty value into a shadow register. The active compare register takes that value only when the timer wraps, so a period that has already started is never changed part-way through. At each wrap the output goes high and a sticky period flag is set. The output goes low when the timer reaches the active duty value.

A second mode, chosen by a control bit, turns the channel into a single-match comparator. In that mode the output goes high, and a compare flag is set, when the timer reaches the compare value. Two power inputs are honoured. Sleep freezes every register and ignores the register bus. Idle halts the channel only when either of two stop-in-idle control bits is set.

Registers are written through a write-enable bus: an address, a 16-bit data word and a strobe. There is no read path. The timer, the output, the flags and the interrupt requests come out as ports.

Top module: `pwm_oc_channel`

## Requirements
- R1: The timer advances by one every QDIV (default 4) clocks times the prescale divisor. The prescale field is control bits [2:1], with 0→1, 1→8, 2→64 and 3→256. One PWM period therefore lasts (period+1)·QDIV·divisor clocks.
- R2: On the tick where the timer equals the period register (address 1), four things happen at the same edge. The timer becomes 0, the shadow duty (address 2) is copied to the active compare register, the output goes high if that shadow value is non-zero, and the period flag (flag bit 0) is set.
- R3: In PWM mode (control bit 5 = 1) the output goes low at the edge where the timer steps to the active duty value D. For 1 ≤ D ≤ period, the output is therefore high for D·QDIV·divisor clocks of each period.
- R4: An active duty of 0 keeps the output low for the whole period.
- R5: An active duty greater than the period register keeps the output high for the whole period.
- R6: A shadow duty written part-way through a period has no effect on the output until the next wrap.
- R7: In PWM mode the compare flag (flag bit 1) is never set. In single-match mode (control bit 5 = 0) the compare value follows the shadow register, and the output goes high and the compare flag is set when the timer steps to that value. A control write that changes bit 5 drives the output low.
- R8: Flags stay set until a write to address 4 with a 1 in the flag's bit position. period_irq equals the period flag AND control bit 6; cmp_irq equals the compare flag AND control bit 7.
- R9: While sleep is high, no register changes and bus writes are ignored. The output keeps its level, and counting resumes when sleep falls.
- R10: While idle is high, the timer halts if control bit 3 (timer stop-in-idle) or control bit 4 (channel stop-in-idle) is 1. It keeps counting when both are 0.
- R11: With control bit 0 (timer enable) at 0, the timer and the output hold their values.
- R12: After reset the timer, the registers and the flags are 0 and the output is low. A write to the timer (address 3) loads it and restarts the divide-by-QDIV and prescale counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 period, 2 shadow duty, 3 timer, 4 flag clear |
| wr_data | input | 16 | Write data |
| sleep | input | 1 | Sleep request: freeze everything |
| idle | input | 1 | Idle request: halt if a stop-in-idle bit is set |
| pwm_out | output | 1 | Channel output |
| tmr_val | output | TW | Current timer value |
| per_flag | output | 1 | Sticky period flag |
| cmp_flag | output | 1 | Sticky compare flag |
| per_irq | output | 1 | Period flag gated by its enable |
| cmp_irq | output | 1 | Compare flag gated by its enable |

## Verification
A prescale count that is wrong, or that is not cleared, shows up in the timer port: an off-by-one step appears within one prescale interval of a timer write. An active compare register loaded at the wrong moment first shows up as a wrong high time in the period after the write. Measuring whole periods exposes it within two periods. Frozen-state faults in sleep, idle or enable-low show up as timer motion at once. The bench compares measured high times and period lengths against formulas for random periods, duties and prescales.

// File: rtl/oc_pkg.sv
package oc_pkg;

  // Control register layout (packed, MSB first): bit7 down to bit0
  typedef struct packed {
    logic       cmp_ie;    // bit 7
    logic       per_ie;    // bit 6
    logic       pwm_mode;  // bit 5
    logic       ch_sidl;   // bit 4
    logic       tm_sidl;   // bit 3
    logic [1:0] psel;      // bits 2:1
    logic       ten;       // bit 0
  } ctrl_t;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_PER  = 3'd1,
    A_DUTY = 3'd2,
    A_TMR  = 3'd3,
    A_FLAG = 3'd4
  } addr_e;

  // Prescale divisor for the 2-bit select field
  function automatic logic [8:0] presc_div(input logic [1:0] sel);
    case (sel)
      2'd0:    presc_div = 9'd1;
      2'd1:    presc_div = 9'd8;
      2'd2:    presc_div = 9'd64;
      default: presc_div = 9'd256;
    endcase
  endfunction

endpackage

// File: rtl/oc_tick_gen.sv
module oc_tick_gen #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] psel,
  output logic       tick
);
  import oc_pkg::*;

  localparam int QW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [QW-1:0] qcnt;
  logic [7:0]    pcnt;
  logic          qtick;
  logic [8:0]    lim;

  assign lim   = presc_div(psel);
  assign qtick = run && (qcnt == QW'(QDIV - 1));
  assign tick  = qtick && ({1'b0, pcnt} >= (lim - 9'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt <= '0;
      pcnt <= '0;
    end else if (clr) begin
      qcnt <= '0;
      pcnt <= '0;
    end else if (run) begin
      qcnt <= qtick ? '0 : qcnt + 1'b1;
      if (qtick) pcnt <= tick ? 8'd0 : pcnt + 8'd1;
    end
  end

  // R1: with more than one clock per timer step, ticks never come back to back
  generate
    if (QDIV > 1) begin : g_spacing
      p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/oc_timebase.sv
module oc_timebase #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tmr_wr,
  input  logic [TW-1:0] wr_val,
  input  logic [TW-1:0] per,
  output logic [TW-1:0] tmr,
  output logic          roll,
  output logic [TW-1:0] nxt
);

  assign roll = tick && (tmr == per);
  assign nxt  = roll ? '0 : tmr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr <= '0;
    else if (tmr_wr) tmr <= wr_val;
    else if (tick)   tmr <= nxt;
  end

  // R2: a wrap without a competing timer write leaves the timer at zero
  p_roll_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && !tmr_wr) |=> (tmr == '0));

  // R11: no tick and no write means the timer holds
  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !tmr_wr) |=> $stable(tmr));

endmodule

// File: rtl/oc_compare.sv
module oc_compare #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          roll,
  input  logic [TW-1:0] nxt,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] per,
  input  logic [TW-1:0] shadow,
  input  logic          pwm_mode,
  input  logic          mode_chg,
  output logic          out,
  output logic          cmp_hit
);

  logic [TW-1:0] active;
  logic          duty_hit;

  assign duty_hit = tick && (nxt == active);
  assign cmp_hit  = !pwm_mode && duty_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
      out    <= 1'b0;
    end else begin
      if (!pwm_mode || roll) active <= shadow;
      if (mode_chg)          out <= 1'b0;
      else if (pwm_mode) begin
        if (roll)            out <= (shadow != '0);
        else if (duty_hit)   out <= 1'b0;
      end else if (cmp_hit)  out <= 1'b1;
    end
  end

  // R4: a zero duty taken at the wrap keeps the output low
  p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && roll && shadow == '0 && !mode_chg) |=> !out);

  // R2: a non-zero duty taken at the wrap drives the output high
  p_wrap_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && roll && shadow != '0 && !mode_chg) |=> out);

  // R5: a duty above the period cannot be reached inside the period
  p_over_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && tick && !roll && !mode_chg && active > per && tmr < per)
      |=> $stable(out));

  // R6: in PWM mode the active duty moves only at a wrap
  p_latch_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !roll) |=> $stable(active));

endmodule

// File: rtl/pwm_oc_channel.sv
module pwm_oc_channel #(
  parameter int TW   = 16,
  parameter int QDIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          sleep,
  input  logic          idle,
  output logic          pwm_out,
  output logic [TW-1:0] tmr_val,
  output logic          per_flag,
  output logic          cmp_flag,
  output logic          per_irq,
  output logic          cmp_irq
);
  import oc_pkg::*;

  ctrl_t         ctrl;
  logic [TW-1:0] per_q;
  logic [TW-1:0] shadow_q;
  logic          wr_ok, run, tick, roll, cmp_hit;
  logic          tmr_wr, flag_wr, mode_chg;
  logic [TW-1:0] nxt, tmr_q, wr_val;

  assign wr_ok    = wr_en && !sleep;
  assign wr_val   = TW'(wr_data);
  assign tmr_wr   = wr_ok && (wr_addr == A_TMR);
  assign flag_wr  = wr_ok && (wr_addr == A_FLAG);
  assign mode_chg = wr_ok && (wr_addr == A_CTRL) && (wr_data[5] != ctrl.pwm_mode);
  assign run      = ctrl.ten && !sleep && !(idle && (ctrl.tm_sidl || ctrl.ch_sidl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      per_q    <= '0;
      shadow_q <= '0;
    end else if (wr_ok) begin
      case (wr_addr)
        A_CTRL:  ctrl     <= ctrl_t'(wr_data[7:0]);
        A_PER:   per_q    <= wr_val;
        A_DUTY:  shadow_q <= wr_val;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      per_flag <= (per_flag & ~(flag_wr & wr_data[0])) | roll;
      cmp_flag <= (cmp_flag & ~(flag_wr & wr_data[1])) | cmp_hit;
    end
  end

  oc_tick_gen #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(tmr_wr),
    .psel(ctrl.psel), .tick(tick)
  );

  oc_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tmr_wr(tmr_wr), .wr_val(wr_val),
    .per(per_q), .tmr(tmr_q), .roll(roll), .nxt(nxt)
  );

  oc_compare #(.TW(TW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .roll(roll), .nxt(nxt),
    .tmr(tmr_q), .per(per_q), .shadow(shadow_q), .pwm_mode(ctrl.pwm_mode),
    .mode_chg(mode_chg), .out(pwm_out), .cmp_hit(cmp_hit)
  );

  assign tmr_val = tmr_q;
  assign per_irq = per_flag & ctrl.per_ie;
  assign cmp_irq = cmp_flag & ctrl.cmp_ie;

  // R7: the compare flag cannot rise while PWM mode is selected
  p_no_cmp_in_pwm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pwm_mode && !cmp_flag) |=> !cmp_flag);

  // R8: a set period flag stays set unless its clear bit is written
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_flag && !(flag_wr && wr_data[0])) |=> per_flag);

  // R9: sleep freezes output, timer and flags
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(pwm_out) && $stable(tmr_q) && $stable(per_flag) && $stable(cmp_flag)));

  // R10: idle with a stop bit set halts the timer
  p_idle_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (ctrl.tm_sidl || ctrl.ch_sidl) && !wr_en) |=> $stable(tmr_q));

endmodule

// File: tb/pwm_oc_channel_test.sv
`timescale 1ns/1ps
module pwm_oc_channel_test;

  localparam int TW = 16;
  localparam int QD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          sleep = 1'b0;
  logic          idle = 1'b0;
  logic          pwm_out;
  logic [TW-1:0] tmr_val;
  logic          per_flag, cmp_flag, per_irq, cmp_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pwm_oc_channel #(.TW(TW), .QDIV(QD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sleep(sleep), .idle(idle), .pwm_out(pwm_out), .tmr_val(tmr_val),
    .per_flag(per_flag), .cmp_flag(cmp_flag), .per_irq(per_irq), .cmp_irq(cmp_irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 180000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<180000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input bit cie, input bit pie, input bit pwm,
                                          input bit chs, input bit tms, input int sel,
                                          input bit en);
    return {8'd0, cie, pie, pwm, chs, tms, 2'(sel), en};
  endfunction

  function automatic int div_of(input int sel);
    return (sel == 3) ? 256 : (1 << (3 * sel));
  endfunction

  function automatic int exp_high(input int d, input int pr, input int sel);
    int cnt;
    cnt = (d > pr) ? pr + 1 : d;
    return cnt * QD * div_of(sel);
  endfunction

  function automatic int exp_len(input int pr, input int sel);
    return (pr + 1) * QD * div_of(sel);
  endfunction

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // wait for the first negedge sample of a new period (timer back to zero)
  task automatic sync_start();
    int prev;
    prev = int'(tmr_val);
    forever begin
      @(negedge clk);
      if (tmr_val == 0 && prev != 0) break;
      prev = int'(tmr_val);
    end
  endtask

  task automatic measure(output int hi, output int len);
    int prev;
    sync_start();
    hi = pwm_out ? 1 : 0;
    len = 1;
    prev = int'(tmr_val);
    forever begin
      @(negedge clk);
      if (tmr_val == 0 && prev != 0) break;
      prev = int'(tmr_val);
      len++;
      if (pwm_out) hi++;
    end
  endtask

  task automatic configure(input int pr, input int sel, input int d);
    bus_wr(0, mk_ctrl(0, 0, 1, 0, 0, sel, 0));
    bus_wr(1, pr);
    bus_wr(2, d);
    bus_wr(3, 0);
    bus_wr(0, mk_ctrl(0, 0, 1, 0, 0, sel, 1));
  endtask

  task automatic run_case(input string tag, input int pr, input int sel, input int d);
    int hi, len;
    configure(pr, sel, d);
    measure(hi, len);
    check({tag, " high clocks"}, hi, exp_high(d, pr, sel));
    check({tag, " period clocks (R1)"}, len, exp_len(pr, sel));
  endtask

  initial begin
    int hi, len, cap_t, cap_o;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    check("R12 reset out", int'(pwm_out), 0);
    check("R12 reset timer", int'(tmr_val), 0);
    check("R12 reset per_flag", int'(per_flag), 0);
    check("R12 reset cmp_flag", int'(cmp_flag), 0);
    check("R12 reset irqs", int'(per_irq) + int'(cmp_irq), 0);

    // R3, R4, R5, R1 directed corners
    run_case("R3 mid duty", 9, 0, 4);
    run_case("R4 zero duty", 9, 0, 0);
    run_case("R5 duty above period", 9, 0, 11);
    run_case("R5 duty equals period+1", 9, 0, 10);
    run_case("R3 duty equals period", 9, 0, 9);
    run_case("R1 prescale 64", 4, 2, 2);
    run_case("R1 prescale 256", 3, 3, 1);

    // R2, R3: random periods, duties and prescales
    for (int i = 0; i < 10; i++) begin
      int pr, sel, d;
      pr  = 3 + int'($urandom_range(0, 27));
      sel = int'($urandom_range(0, 1));
      d   = int'($urandom_range(0, pr + 3));
      run_case("R2 R3 random", pr, sel, d);
    end

    // R7: PWM runs never set the compare flag
    check("R7 no compare flag in PWM", int'(cmp_flag), 0);
    // R8: period flag set by wraps, irq follows enable
    check("R8 period flag sticky", int'(per_flag), 1);
    check("R8 irq gated off", int'(per_irq), 0);

    // R6: mid-period duty write waits for the wrap
    configure(20, 0, 25);
    sync_start();
    bus_wr(2, 1);
    repeat (20) @(negedge clk);
    check("R6 output unchanged after mid-period write", int'(pwm_out), 1);
    measure(hi, len);
    check("R6 new duty used next period", hi, exp_high(1, 20, 0));

    // R8: clear and re-set with long period
    configure(200, 0, 50);
    bus_wr(0, mk_ctrl(0, 1, 1, 0, 0, 0, 1));
    sync_start();
    check("R8 irq gated on", int'(per_irq), 1);
    bus_wr(4, 1);
    check("R8 flag cleared by write", int'(per_flag), 0);
    check("R8 irq follows clear", int'(per_irq), 0);
    sync_start();
    check("R8 flag set again at wrap", int'(per_flag), 1);

    // R9: sleep freezes and ignores writes
    configure(30, 0, 10);
    sync_start();
    repeat (9) @(negedge clk);
    sleep = 1'b1;
    cap_t = int'(tmr_val);
    cap_o = int'(pwm_out);
    bus_wr(3, 25);
    repeat (100) @(negedge clk);
    check("R9 timer frozen in sleep", int'(tmr_val), cap_t);
    check("R9 output frozen in sleep", int'(pwm_out), cap_o);
    sleep = 1'b0;
    repeat (9) @(negedge clk);
    check("R9 timer resumes after wake", int'(tmr_val), cap_t + 2);

    // R10: idle with stop bits
    configure(500, 0, 100);
    bus_wr(0, mk_ctrl(0, 0, 1, 0, 1, 0, 1));
    idle = 1'b1;
    @(negedge clk);
    cap_t = int'(tmr_val);
    repeat (40) @(negedge clk);
    check("R10 timer stop-in-idle halts", int'(tmr_val), cap_t);
    bus_wr(0, mk_ctrl(0, 0, 1, 1, 0, 0, 1));
    cap_t = int'(tmr_val);
    repeat (40) @(negedge clk);
    check("R10 channel stop-in-idle halts", int'(tmr_val), cap_t);
    bus_wr(0, mk_ctrl(0, 0, 1, 0, 0, 0, 1));
    cap_t = int'(tmr_val);
    repeat (40) @(negedge clk);
    check("R10 runs in idle with both bits clear", int'(tmr_val), cap_t + 10);
    idle = 1'b0;

    // R11: enable low holds timer and output
    configure(30, 0, 200);
    sync_start();
    bus_wr(0, mk_ctrl(0, 0, 1, 0, 0, 0, 0));
    cap_t = int'(tmr_val);
    cap_o = int'(pwm_out);
    repeat (60) @(negedge clk);
    check("R11 timer holds when disabled", int'(tmr_val), cap_t);
    check("R11 output holds when disabled", int'(pwm_out), cap_o);

    // R12: timer write restarts the prescale count
    bus_wr(1, 1000);
    bus_wr(0, mk_ctrl(0, 0, 1, 0, 0, 3, 1));
    repeat (301) @(negedge clk);
    bus_wr(3, 7);
    repeat (1023) @(negedge clk);
    check("R12 timer held for full prescale", int'(tmr_val), 7);
    @(negedge clk);
    check("R12 timer steps after full prescale", int'(tmr_val), 8);

    // R7: single-match mode
    bus_wr(0, mk_ctrl(1, 0, 0, 0, 0, 0, 0));
    bus_wr(1, 50);
    bus_wr(2, 10);
    bus_wr(3, 0);
    bus_wr(4, 3);
    check("R7 mode change drives output low", int'(pwm_out), 0);
    bus_wr(0, mk_ctrl(1, 0, 0, 0, 0, 0, 1));
    while (tmr_val != 9) @(negedge clk);
    check("R7 output low before match", int'(pwm_out), 0);
    check("R7 compare flag clear before match", int'(cmp_flag), 0);
    while (tmr_val != 11) @(negedge clk);
    check("R7 output high after match", int'(pwm_out), 1);
    check("R7 compare flag set on match", int'(cmp_flag), 1);
    check("R8 compare irq with enable", int'(cmp_irq), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule